// File: doc/BRIEF.md
# Single-Float Register Format Converter

This block moves single-precision values between their 32-bit storage layout and the 64-bit layout that a floating-point register file uses for them. When it expands a stored value, it widens the 8-bit exponent to 11 bits and keeps infinities, NaNs and zeros distinguishable. When it compresses, it takes the sign, the exponent top bit and a 30-bit body back out of two separate register fields. A third operation places the low 32 bits of a 64-bit integer into the register-resident 32-bit-integer layout. It also reports when the integer does not fit in 32 signed bits.

Each operation is a fixed bit repacking, so no rounding takes place. The block has one registered stage. A valid strobe travels beside the data, so a pipeline can issue one conversion on every clock.

Top module: `sf_regfmt_conv`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid`, `out_data`, `out_iov` and `out_ine` are all zero.
- R2: `out_valid` equals the value that `in_valid` had one clock earlier.
- R3: Expand (op code 0) takes its operand from `in_data[31:0]`. The result has bit 31 of the operand in bit 63, operand bits 22:0 in bits 51:29, and zeros in bits 28:0.
- R4: Expand builds the 11-bit exponent in result bits 62:52 from the 8-bit field in operand bits 30:23. A field of 255 gives 2047 and a field of 0 gives 0. Any other field value f gives f + 896.
- R5: Compress (op code 1) returns register bits 63:62 in `out_data[31:30]` and register bits 58:29 in `out_data[29:0]`. `out_data[63:32]` is zero.
- R6: Pack (op code 2) places operand bits 31:30 in result bits 63:62 and operand bits 29:0 in result bits 58:29. Every other result bit is zero.
- R7: For pack, `out_iov` and `out_ine` are both set when bits 63:31 of the operand are not all equal, which means the value is not the sign extension of its low 32 bits. Otherwise both are clear.
- R8: Expand, compress and op code 3 always return both flags as zero.
- R9: Op code 3 is unused and returns an all-zero result.
- R10: A cycle with `in_valid` low leaves `out_data`, `out_iov` and `out_ine` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and op code are valid this cycle |
| in_op | input | 2 | 0 expand, 1 compress, 2 pack integer, 3 unused |
| in_data | input | 64 | Operand; expand uses bits 31:0 |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Converted value |
| out_iov | output | 1 | Integer overflow flag for pack |
| out_ine | output | 1 | Inexact flag for pack |

## Verification
The bench tests expand on exponent fields of 0, 1, 126, 127, 128, 254 and 255, each with and without a fraction and under both signs. These values separate the four exponent branches and expose a wrong 0x380 or 0x7FF mapping. For compress, the bench uses registers with one bit set at a time and registers whose bits 61:59 and 28:0 are filled with noise, which shows whether the skipped field really is skipped. For pack, the bench uses the signed 32-bit extremes, the values one step beyond them, and values whose upper word has mixed bits, which separates a correct sign-extension test from a test that only looks at the top bit. Random bursts with gaps in `in_valid` check that the output holds and that the valid strobe keeps its alignment.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int REG_W    = 64;
  localparam int MEM_W    = 32;
  localparam int SEXP_W   = 8;
  localparam int TEXP_W   = 11;
  localparam int FRAC_W   = 23;
  localparam int PAD_W    = REG_W - 1 - TEXP_W - FRAC_W;   // 29
  localparam int BODY_W   = MEM_W - 2;                     // 30
  localparam int GAP_W    = REG_W - 2 - BODY_W - PAD_W;    // 3

  typedef enum logic [1:0] {
    SFC_EXPAND   = 2'd0,
    SFC_COMPRESS = 2'd1,
    SFC_PACK     = 2'd2,
    SFC_NONE     = 2'd3
  } sfc_op_e;
endpackage

// File: rtl/sf_expand.sv
module sf_expand
  import sfc_pkg::*;
(
  input  logic [MEM_W-1:0] mem_i,
  output logic [REG_W-1:0] reg_o
);
  localparam int LOW_W = SEXP_W - 1;

  logic              sgn;
  logic              e_top;
  logic [LOW_W-1:0]  e_low;
  logic [FRAC_W-1:0] frac;
  logic [TEXP_W-1:0] e_wide;

  assign sgn   = mem_i[MEM_W-1];
  assign e_top = mem_i[MEM_W-2];
  assign e_low = mem_i[MEM_W-3 -: LOW_W];
  assign frac  = mem_i[FRAC_W-1:0];

  // R4: widen exponent keeping specials distinct
  always_comb begin
    if (e_top) begin
      if (&e_low) e_wide = '1;
      else        e_wide = {1'b1, {(TEXP_W-SEXP_W){1'b0}}, e_low};
    end else begin
      if (|e_low) e_wide = {1'b0, {(TEXP_W-SEXP_W){1'b1}}, e_low};
      else        e_wide = '0;
    end
  end

  assign reg_o = {sgn, e_wide, frac, {PAD_W{1'b0}}};
endmodule

// File: rtl/sf_compress.sv
module sf_compress
  import sfc_pkg::*;
(
  input  logic [1:0]        top_i,
  input  logic [BODY_W-1:0] body_i,
  output logic [MEM_W-1:0]  mem_o
);
  assign mem_o = {top_i, body_i};
endmodule

// File: rtl/sf_intpack.sv
module sf_intpack
  import sfc_pkg::*;
(
  input  logic [REG_W-1:0] val_i,
  output logic [REG_W-1:0] reg_o,
  output logic             ovf_o
);
  logic [REG_W-MEM_W:0] upper;   // bits 63:31
  assign upper = val_i[REG_W-1:MEM_W-1];

  // R7: value fits only when upper bits are a pure sign copy
  assign ovf_o = ~((&upper) | ~(|upper));

  assign reg_o = {val_i[MEM_W-1:MEM_W-2], {GAP_W{1'b0}},
                  val_i[BODY_W-1:0], {PAD_W{1'b0}}};
endmodule

// File: rtl/sf_regfmt_conv.sv
module sf_regfmt_conv
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [REG_W-1:0] in_data,
  output logic             out_valid,
  output logic [REG_W-1:0] out_data,
  output logic             out_iov,
  output logic             out_ine
);
  logic [REG_W-1:0] exp_res;
  logic [MEM_W-1:0] cmp_res;
  logic [REG_W-1:0] pck_res;
  logic             pck_ovf;
  logic [REG_W-1:0] nxt_data;
  logic             nxt_flag;
  sfc_op_e          op;

  assign op = sfc_op_e'(in_op);

  sf_expand u_exp (
    .mem_i (in_data[MEM_W-1:0]),
    .reg_o (exp_res)
  );

  sf_compress u_cmp (
    .top_i  (in_data[REG_W-1:REG_W-2]),
    .body_i (in_data[REG_W-2-GAP_W-1:PAD_W]),
    .mem_o  (cmp_res)
  );

  sf_intpack u_pck (
    .val_i (in_data),
    .reg_o (pck_res),
    .ovf_o (pck_ovf)
  );

  always_comb begin
    nxt_data = '0;
    nxt_flag = 1'b0;
    unique case (op)
      SFC_EXPAND:   nxt_data = exp_res;
      SFC_COMPRESS: nxt_data = {{(REG_W-MEM_W){1'b0}}, cmp_res};
      SFC_PACK: begin
        nxt_data = pck_res;
        nxt_flag = pck_ovf;
      end
      default:      nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_iov   <= 1'b0;
      out_ine   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_iov  <= nxt_flag;
        out_ine  <= nxt_flag;
      end
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_expand_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == SFC_EXPAND) |=> (out_data[PAD_W-1:0] == '0));
  assert_compress_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == SFC_COMPRESS) |=> (out_data[REG_W-1:MEM_W] == '0));
  assert_flags_pair_R7: assert property (@(posedge clk) disable iff (rst)
    out_iov == out_ine);
  assert_flags_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != SFC_PACK) |=> !out_iov);
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == SFC_NONE) |=> (out_data == '0));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_iov)));
endmodule

// File: tb/sim_sf_regfmt_conv.sv
module sim_sf_regfmt_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_iov, out_ine;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state: what outputs should show after the next edge
  logic        m_valid = 0;
  logic [63:0] m_data = '0;
  logic        m_flag = 0;
  int          m_op = 0;

  always #2.5 clk = ~clk;

  sf_regfmt_conv u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_iov(out_iov), .out_ine(out_ine)
  );

  function automatic logic [63:0] ref_expand(input logic [31:0] m);
    int e8;
    longint unsigned e11;
    e8 = int'((m >> 23) & 32'hFF);
    if (e8 == 255)    e11 = 2047;
    else if (e8 == 0) e11 = 0;
    else              e11 = longint'(e8 + 896);
    return (longint'(m[31]) << 63) | (e11 << 52) |
           ((longint'(m) & 64'h7FFFFF) << 29);
  endfunction

  function automatic logic [63:0] ref_compress(input logic [63:0] r);
    return (((r >> 62) & 64'h3) << 30) | ((r >> 29) & 64'h3FFFFFFF);
  endfunction

  function automatic logic [63:0] ref_pack(input logic [63:0] v);
    return (((v >> 30) & 64'h3) << 62) | ((v & 64'h3FFFFFFF) << 29);
  endfunction

  function automatic bit ref_ovf(input logic [63:0] v);
    longint sv;
    sv = longint'(v);
    return (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
  endfunction

  task automatic check_now();
    string tag;
    total++;
    if (out_valid !== m_valid) begin
      bad++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, m_valid);
    end
    case (m_op)
      0: tag = "R3/R4 expand";
      1: tag = "R5 compress";
      2: tag = "R6 pack";
      3: tag = "R9 unused op";
      default: tag = "R1 reset";
    endcase
    total++;
    if (out_data !== m_data) begin
      bad++;
      $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, m_data);
    end
    total++;
    if (out_iov !== m_flag || out_ine !== m_flag) begin
      bad++;
      $display("FAIL %s flags (R7/R8) actual=%0b%0b expected=%0b%0b",
               tag, out_iov, out_ine, m_flag, m_flag);
    end
  endtask

  // one cycle: check current outputs, drive next inputs, advance model
  task automatic step(input bit r, input bit v, input int op, input logic [63:0] d);
    @(negedge clk);
    check_now();
    rst = r; in_valid = v; in_op = op[1:0]; in_data = d;
    if (r) begin
      m_valid = 0; m_data = '0; m_flag = 0; m_op = 4;
    end else begin
      m_valid = v;
      if (v) begin   // R10: otherwise model holds
        m_op = op;
        case (op)
          0: begin m_data = ref_expand(d[31:0]); m_flag = 0; end
          1: begin m_data = ref_compress(d);     m_flag = 0; end
          2: begin m_data = ref_pack(d);         m_flag = ref_ovf(d); end
          default: begin m_data = '0;            m_flag = 0; end
        endcase
      end
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exps[7] = '{0, 1, 126, 127, 128, 254, 255};
    logic [63:0] packs[10] = '{64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
                               64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_7FFF_FFFF,
                               64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
                               64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000,
                               64'h7FFF_FFFF_C000_0001, 64'hFFFF_FFFE_8000_0000};
    // R1: reset state (model set to zero in reset cycles)
    m_op = 4;
    step(1, 1, 2, 64'hFFFF_0000_1234_5678);
    step(1, 0, 0, '0);
    step(0, 0, 0, '0);
    // R3/R4 expand corner exponents, both signs, with/without fraction
    foreach (exps[i]) begin
      for (int s = 0; s < 2; s++) begin
        step(0, 1, 0, {32'hDEAD_BEEF, 1'(s), 8'(exps[i]), 23'h0});
        step(0, 1, 0, {32'h0, 1'(s), 8'(exps[i]), 23'h55AA33});
      end
    end
    // R5 compress: walking ones and noise in skipped fields
    for (int b = 0; b < 64; b++) step(0, 1, 1, 64'h1 << b);
    step(0, 1, 1, 64'h3800_0000_1FFF_FFFF);
    step(0, 1, 1, 64'hC7FF_FFFF_E000_0000);
    // R6/R7 pack extremes
    foreach (packs[i]) step(0, 1, 2, packs[i]);
    // R9 unused op, R10 hold with gaps
    step(0, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    step(0, 1, 2, 64'h0000_0001_0000_0000);
    step(0, 0, 0, 64'h0);
    step(0, 0, 1, 64'h1234);
    step(0, 1, 0, 64'h3F80_0000);
    // random bursts with gaps
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if (k % 3 == 0) d = {{32{d[31]}}, d[31:0]};
      step(0, ($urandom % 4) != 0, int'($urandom % 4), d);
    end
    // R1 again: mid-run reset
    step(1, 1, 0, 64'h7F80_0000);
    step(0, 0, 0, '0);
    step(0, 0, 0, '0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule